// File: doc/BRIEF.md
# Program-Start Qualifier with Power-Up Lockout and Strobe Width Filter

This block stands between the control pins of a flash-style memory and its program engine. It decides whether a write strobe may start a program cycle. Its inputs are the supply-good comparator output and the chip-select, read-enable and write-strobe controls, all already synchronised to the block clock. Its output is a one-cycle `prog_start` pulse that the program engine uses to begin a cycle.

A strobe is a run of clock edges on which chip-select and write-strobe are both low. The block accepts a strobe only when all of these hold: the supply has been good for a full power-up delay, read-enable is high, and the strobe is long enough to rule out a glitch. Both the delay and the minimum width are parameters in clock cycles. A loss of supply at any time restarts the delay. An inhibit seen on any edge of a strobe rejects the whole strobe.

Top module: `prog_start_qual`

## Requirements
- R1: While `supply_ok` is 0 no strobe is accepted. A strobe with any active edge that samples `supply_ok` = 0 produces no pulse.
- R2: After reset, an edge permits programming only after at least `DELAY_CYCLES` earlier consecutive edges have sampled `supply_ok` = 1.
- R3: An edge that samples `supply_ok` = 0 clears the power-up count. The full `DELAY_CYCLES` run of good edges is then needed again.
- R4: An active strobe edge that samples `oe_n` = 0 rejects that strobe.
- R5: A strobe edge is an edge that samples `ce_n` = 0 and `we_n` = 0. With either of them high there is no strobe, whatever the other one does.
- R6: A strobe shorter than `MIN_WIDTH` consecutive active edges produces no pulse. A strobe of exactly `MIN_WIDTH` active edges is accepted.
- R7: An accepted strobe gives exactly one `prog_start` pulse, one cycle long. It is high in the cycle after the first edge that samples the strobe inactive.
- R8: A strobe with any inhibited active edge gives no pulse, even if the inhibit clears before the strobe ends.
- R9: The synchronous active-low reset clears `prog_start` and the power-up count. The first edge after reset starts a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok | input | 1 | Supply-above-threshold comparator output, synchronised |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low; low inhibits programming |
| we_n | input | 1 | Write strobe, active low |
| prog_start | output | 1 | One-cycle qualified program-start pulse |

## Verification
A supply dip can land on the same edge as the last active cycle of a strobe that is otherwise long enough and clean. The lockout and the width filter then act on that one edge. The bench provokes this by pulling `supply_ok` low for a single cycle exactly on the final active edge. It expects no pulse, and it expects the full delay to be needed again before the next strobe is accepted. A behavioural model made of integer counters predicts `prog_start` on every cycle, so any skew between the two paths shows up as a cycle mismatch.

// File: rtl/pqual_pkg.sv
// Package for the program-start qualifier.
// Holds the strobe event record shared by the strobe tracker and the top.
package pqual_pkg;

    // Events of the strobe at one clock edge.
    typedef struct packed {
        logic starts;   // first active edge of a strobe
        logic held;     // active edge that continues a strobe
        logic ends;     // first inactive edge after a strobe
    } strobe_ev_t;

    // Works out the strobe events from the current and previous activity.
    function automatic strobe_ev_t classify(input logic now_act, input logic was_act);
        strobe_ev_t ev;
        ev.starts = now_act & ~was_act;
        ev.held   = now_act &  was_act;
        ev.ends   = ~now_act & was_act;
        return ev;
    endfunction

endpackage

// File: rtl/pq_power_gate.sv
// Power-up lockout.
// Counts consecutive edges on which supply_ok is high, saturating at
// DELAY_CYCLES. ready goes high once the count reaches the limit.
// Any edge with supply_ok low clears the count.
// Assumes supply_ok is already synchronised. DELAY_CYCLES >= 1.
module pq_power_gate #(
    parameter int DELAY_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic ready
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);

    logic [CW-1:0] good_run;

    // Counts good-supply edges; a bad edge restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_run <= '0;
        end else if (!supply_ok) begin
            good_run <= '0;
        end else if (good_run != LIMIT) begin
            good_run <= good_run + 1'b1;
        end
    end

    // Lockout is released once the count saturates.
    always_comb ready = (good_run == LIMIT);

    // R1 / R3: a bad supply edge always re-arms the lockout
    p_low_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !ready);
    // R3: the lockout only re-engages because the supply dropped
    p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> !$past(supply_ok));
    // R2: once released, the lockout stays released while the supply holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && supply_ok) |=> ready);

endmodule

// File: rtl/pq_strobe_track.sv
// Strobe width filter and start pulse generator.
// Follows one strobe at a time. It counts the active edges (saturating at
// MIN_WIDTH) and marks the strobe spoiled if permit is low on any active
// edge. On the first inactive edge it fires a one-cycle pulse if the strobe
// was long enough and never spoiled.
// Assumes active and permit are functions of synchronised inputs.
module pq_strobe_track
    import pqual_pkg::*;
#(
    parameter int MIN_WIDTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic permit,
    output logic fire
);
    localparam int WW = $clog2(MIN_WIDTH + 1);
    localparam logic [WW-1:0] NEED = WW'(MIN_WIDTH);

    logic          was_active;
    logic [WW-1:0] width_cnt;
    logic          spoiled;
    logic          width_met;
    strobe_ev_t    ev;

    // Decodes this edge's strobe event.
    always_comb begin
        ev        = classify(active, was_active);
        width_met = (width_cnt == NEED);
    end

    // Follows the strobe: width count, spoil flag and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_active <= 1'b0;
            width_cnt  <= '0;
            spoiled    <= 1'b0;
            fire       <= 1'b0;
        end else begin
            was_active <= active;
            fire       <= ev.ends & width_met & ~spoiled;
            if (ev.starts) begin
                width_cnt <= WW'(1);
                spoiled   <= ~permit;
            end else if (ev.held) begin
                if (!width_met) width_cnt <= width_cnt + 1'b1;
                spoiled <= spoiled | ~permit;
            end
        end
    end

    // R7: the start pulse lasts one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R6: a pulse only follows a strobe that reached the minimum width
    p_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(width_met));
    // R8: a pulse never follows a spoiled strobe
    p_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !$past(spoiled));
    // R7: a pulse only follows the end of a strobe
    p_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(was_active) && !$past(active)));

endmodule

// File: rtl/prog_start_qual.sv
// Program-start qualifier, top level.
// A strobe edge is one with ce_n and we_n both low. Programming is
// permitted on an edge when the power-up lockout is released, the supply
// is good and oe_n is high. The strobe tracker turns a permitted strobe of
// enough width into one prog_start pulse.
// Assumes all inputs are synchronised to clk.
module prog_start_qual #(
    parameter int DELAY_CYCLES = 2_000_000,
    parameter int MIN_WIDTH    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic prog_start
);
    logic ready;
    logic permit;
    logic active;

    // Combines the static inhibits and the strobe decode.
    always_comb begin
        permit = ready & supply_ok & oe_n;
        active = ~ce_n & ~we_n;
    end

    pq_power_gate #(.DELAY_CYCLES(DELAY_CYCLES)) u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ready     (ready)
    );

    pq_strobe_track #(.MIN_WIDTH(MIN_WIDTH)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .permit (permit),
        .fire   (prog_start)
    );

    // R4: the last active edge before a pulse saw oe_n high
    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(oe_n, 2));
    // R2: the last active edge before a pulse saw the lockout released
    p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(ready, 2));
    // R5: the edge before a pulse's end edge was a real strobe edge
    p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (!$past(ce_n, 2) && !$past(we_n, 2)));

endmodule

// File: tb/prog_start_qual_test.sv
`timescale 1ns/1ps
module prog_start_qual_test;
    localparam int DLY  = 20;
    localparam int MINW = 3;

    logic clk = 1'b0;
    logic rst_n, supply_ok, ce_n, oe_n, we_n;
    logic prog_start;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    string tag = "R9";
    bit compare_on = 1'b0;

    // Reference model state
    int  m_run = 0;
    int  m_len = 0;
    bit  m_prev = 0;
    bit  m_bad = 0;
    bit  m_exp = 0;

    always #2.5 clk = ~clk;

    prog_start_qual #(.DELAY_CYCLES(DLY), .MIN_WIDTH(MINW)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .prog_start(prog_start)
    );

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_len = 0; m_prev = 0; m_bad = 0; m_exp = 0;
        end else begin
            bit ok, act;
            ok  = (m_run >= DLY) && supply_ok && oe_n;
            act = !ce_n && !we_n;
            m_exp = m_prev && !act && (m_len >= MINW) && !m_bad;
            if (act && !m_prev) begin
                m_len = 1; m_bad = !ok;
            end else if (act) begin
                m_len = m_len + 1; m_bad = m_bad | !ok;
            end
            m_prev = act;
            m_run = supply_ok ? m_run + 1 : 0;
        end
    end

    // Cycle comparison and pulse count at the falling edge.
    always @(negedge clk) begin
        if (prog_start === 1'b1) pulses++;
        if (compare_on) begin
            checks++;
            if (prog_start !== m_exp) begin
                errors++;
                $display("FAIL %s cycle compare: actual=%b expected=%b at %0t",
                         tag, prog_start, m_exp, $time);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 0: ce_n and we_n together; 1: ce_n pulse with we_n held low;
    // 2: we_n pulse with ce_n held high (no strobe)
    task automatic strobe(input int width, input int mode);
        @(negedge clk);
        if (mode == 0) begin
            ce_n = 1'b0; we_n = 1'b0;
        end else if (mode == 1) begin
            we_n = 1'b0; @(negedge clk); ce_n = 1'b0;
        end else begin
            we_n = 1'b0;
        end
        repeat (width) @(negedge clk);
        ce_n = 1'b1;
        if (mode == 1) @(negedge clk);
        we_n = 1'b1;
        idle(4);
    endtask

    task automatic expect_pulses(input string t, input int base, input int n);
        checks++;
        if (pulses - base != n) begin
            errors++;
            $display("FAIL %s pulse count: actual=%0d expected=%0d", t, pulses - base, n);
        end
    endtask

    initial begin
        int base;
        rst_n = 1'b0; supply_ok = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        idle(4);
        tag = "R9"; checks++;
        if (prog_start !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset value: actual=%b expected=0", prog_start);
        end
        compare_on = 1'b1;
        rst_n = 1'b1;

        tag = "R1"; base = pulses;
        strobe(5, 0);
        expect_pulses("R1", base, 0);

        tag = "R2"; base = pulses;
        supply_ok = 1'b1;
        idle(3);
        strobe(4, 0);
        expect_pulses("R2", base, 0);
        idle(DLY);
        base = pulses;
        strobe(4, 0);
        expect_pulses("R2", base, 1);

        tag = "R6"; base = pulses;
        strobe(MINW - 1, 0);
        expect_pulses("R6", base, 0);
        base = pulses;
        strobe(MINW, 0);
        expect_pulses("R6", base, 1);

        tag = "R5"; base = pulses;
        strobe(MINW - 1, 1);
        expect_pulses("R5", base, 0);
        base = pulses;
        strobe(MINW, 1);
        expect_pulses("R5", base, 1);
        base = pulses;
        strobe(6, 2);
        expect_pulses("R5", base, 0);

        tag = "R7"; base = pulses;
        strobe(12, 0);
        expect_pulses("R7", base, 1);

        tag = "R4"; base = pulses;
        oe_n = 1'b0;
        strobe(5, 0);
        oe_n = 1'b1;
        expect_pulses("R4", base, 0);

        tag = "R8"; base = pulses;
        @(negedge clk); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); oe_n = 1'b1;
        idle(5);
        ce_n = 1'b1; we_n = 1'b1;
        idle(4);
        expect_pulses("R8", base, 0);

        tag = "R3"; base = pulses;
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); supply_ok = 1'b1;
        idle(10);
        strobe(4, 0);
        expect_pulses("R3", base, 0);
        idle(DLY);
        base = pulses;
        strobe(4, 0);
        expect_pulses("R3", base, 1);

        // Supply dip on the final active edge of an otherwise valid strobe.
        tag = "R1"; base = pulses;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
        idle(MINW);
        supply_ok = 1'b0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; supply_ok = 1'b1;
        idle(4);
        expect_pulses("R1", base, 0);
        tag = "R3"; base = pulses;
        strobe(4, 0);
        expect_pulses("R3", base, 0);
        idle(DLY);
        base = pulses;
        strobe(4, 0);
        expect_pulses("R3", base, 1);

        tag = "R9"; base = pulses;
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        strobe(4, 0);
        expect_pulses("R9", base, 0);

        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule